// File: doc/BRIEF.md
# Synchronous RAM Port with Selectable Write Policy

This block is a single-port storage array with a registered read path. Each stored word is a data field with a separate parity field beside it; both are written together and come back together. Reads and writes are taken at the rising clock edge, and the read result appears on the outputs one cycle after the address is presented.

A build-time parameter fixes what the output register shows in a cycle that writes. It can show the word being written, the word the address held before the write, or it can keep its last value. A synchronous set/reset input loads the output register with a constant chosen at build time and leaves the array alone. A port enable gates everything: with it low, the port is frozen.

Top module: `ram_sync_port`

## Requirements
- R1: With `en`=1, `we`=0 and `srst`=0, the `{rdPar, rdData}` outputs show, after the next rising edge, the word stored at `addr`.
- R2: With `en`=1 and `we`=1, the word `{wrPar, wrData}` is stored at `addr` and is returned by any later read of that address until that address is written again.
- R3: With `WRITE_MODE` = `WM_WRITE_FIRST`, a write cycle with `srst`=0 loads the output register with the word being written.
- R4: With `WRITE_MODE` = `WM_READ_FIRST`, a write cycle with `srst`=0 loads the output register with the word that `addr` held before the write.
- R5: With `WRITE_MODE` = `WM_NO_CHANGE`, a write cycle with `srst`=0 leaves the output register unchanged.
- R6: With `en`=1 and `srst`=1, the output register is loaded with `RESET_VAL` (parity in the upper `PAR_W` bits, data in the lower `DATA_W` bits) and the array contents are unchanged.
- R7: When `srst`=1 and `we`=1 in the same enabled cycle, the output takes `RESET_VAL` and the write to the array still takes place.
- R8: With `en`=0, the output register holds, the array is not written whatever `we` is, and `srst` has no effect.
- R9: When no `WRITE_MODE` is given, the block behaves as in R3.
- R10: The parity field is stored and returned independently of the data field: `rdPar` carries the stored parity bits and `rdData` the stored data bits of the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| en | input | 1 | Port enable; gates reads, writes and set/reset |
| we | input | 1 | Write request for the word at `addr` |
| srst | input | 1 | Synchronous load of `RESET_VAL` into the output register |
| addr | input | ADDR_W = clog2(DEPTH) | Word address |
| wrData | input | DATA_W | Data field of the word to write |
| wrPar | input | PAR_W | Parity field of the word to write |
| rdData | output | DATA_W | Registered data field |
| rdPar | output | PAR_W | Registered parity field |

## Verification
The only internal state is the array and the output register, so a wrong array word stays hidden until that address is read, and then shows on the very next edge; the bench therefore reads back every address it writes and also writes and reads the same few addresses many times in a mixed stream. A wrong output-select decision shows one cycle after the faulty cycle, as a word from the wrong source (new data, old data, the held value or the reset constant). Three instances, one per write policy, run the same stream against one reference model, so a fault in any policy branch is exposed in the first collision cycle that exercises it.

// File: rtl/ram_port_pkg.sv
package ram_port_pkg;

  // Read-during-write policy of the output register.
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } writeMode_e;

  // Strobes from control to datapath; at most one load strobe is active.
  typedef struct packed {
    logic arrayWr;     // commit the input word to the array
    logic loadArray;   // output register takes the array word at addr
    logic loadWrWord;  // output register takes the incoming word
    logic loadReset;   // output register takes the reset constant
  } ctrlStrobes_t;

endpackage

// File: rtl/ram_port_ctrl.sv
module ram_port_ctrl
  import ram_port_pkg::*;
#(
  parameter writeMode_e WRITE_MODE = WM_WRITE_FIRST
) (
  input  logic         en,
  input  logic         we,
  input  logic         srst,
  output ctrlStrobes_t strobes
);

  // What a non-reset write cycle does to the output register.
  logic collideArray;
  logic collideWrWord;

  generate
    if (WRITE_MODE == WM_WRITE_FIRST) begin : g_writeFirst
      assign collideArray  = 1'b0;
      assign collideWrWord = 1'b1;
    end else if (WRITE_MODE == WM_READ_FIRST) begin : g_readFirst
      assign collideArray  = 1'b1;
      assign collideWrWord = 1'b0;
    end else begin : g_noChange
      assign collideArray  = 1'b0;
      assign collideWrWord = 1'b0;
    end
  endgenerate

  always_comb begin
    strobes = '0;
    if (en) begin
      strobes.arrayWr = we;
      if (srst) begin
        strobes.loadReset = 1'b1;
      end else if (!we) begin
        strobes.loadArray = 1'b1;
      end else begin
        strobes.loadArray  = collideArray;
        strobes.loadWrWord = collideWrWord;
      end
    end
  end

endmodule

// File: rtl/ram_port_datapath.sv
module ram_port_datapath
  import ram_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 1,
  parameter int DEPTH  = 256,
  parameter logic [DATA_W+PAR_W-1:0] RESET_VAL = '0,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + PAR_W
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrWord,
  output logic [WORD_W-1:0] rdWord
);

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] arrayWord;
  logic [WORD_W-1:0] outReg;

  // Array read sees the contents before this edge's write.
  assign arrayWord = store[addr];

  always_ff @(posedge clk) begin
    if (strobes.arrayWr) begin
      store[addr] <= wrWord;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadReset) begin
      outReg <= RESET_VAL;
    end else if (strobes.loadWrWord) begin
      outReg <= wrWord;
    end else if (strobes.loadArray) begin
      outReg <= arrayWord;
    end
  end

  assign rdWord = outReg;

endmodule

// File: rtl/ram_sync_port.sv
module ram_sync_port
  import ram_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 1,
  parameter int DEPTH  = 256,
  parameter writeMode_e WRITE_MODE = WM_WRITE_FIRST,
  parameter logic [DATA_W+PAR_W-1:0] RESET_VAL = '0,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + PAR_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic              srst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PAR_W-1:0]  wrPar,
  output logic [DATA_W-1:0] rdData,
  output logic [PAR_W-1:0]  rdPar
);

  ctrlStrobes_t      strobes;
  logic [WORD_W-1:0] rdWord;

  ram_port_ctrl #(
    .WRITE_MODE(WRITE_MODE)
  ) u_ctrl (
    .en     (en),
    .we     (we),
    .srst   (srst),
    .strobes(strobes)
  );

  ram_port_datapath #(
    .DATA_W   (DATA_W),
    .PAR_W    (PAR_W),
    .DEPTH    (DEPTH),
    .RESET_VAL(RESET_VAL)
  ) u_datapath (
    .clk    (clk),
    .strobes(strobes),
    .addr   (addr),
    .wrWord ({wrPar, wrData}),
    .rdWord (rdWord)
  );

  assign rdData = rdWord[DATA_W-1:0];
  assign rdPar  = rdWord[WORD_W-1:DATA_W];

endmodule

// File: rtl/ram_sync_port_chk.sv
module ram_sync_port_chk
  import ram_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 1,
  parameter int DEPTH  = 256,
  parameter writeMode_e WRITE_MODE = WM_WRITE_FIRST,
  parameter logic [DATA_W+PAR_W-1:0] RESET_VAL = '0,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + PAR_W
) (
  input logic              clk,
  input logic              en,
  input logic              we,
  input logic              srst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [PAR_W-1:0]  wrPar,
  input logic [DATA_W-1:0] rdData,
  input logic [PAR_W-1:0]  rdPar
);

  // Cycles since the first enabled set/reset, saturating at 3.
  logic [1:0] armCnt = 2'd0;
  logic       armed;
  logic       armedDeep;

  always_ff @(posedge clk) begin
    if (armCnt != 2'd3 && (armCnt != 2'd0 || (en && srst))) begin
      armCnt <= armCnt + 2'd1;
    end
  end

  assign armed     = (armCnt != 2'd0);
  assign armedDeep = (armCnt == 2'd3);

  logic isWriteFirst;
  logic isNoChange;
  assign isWriteFirst = (WRITE_MODE == WM_WRITE_FIRST);
  assign isNoChange   = (WRITE_MODE == WM_NO_CHANGE);

  AST_RESET_LOADS_CONST: assert property (@(posedge clk) disable iff (!armed)
    (en && srst) |=> ({rdPar, rdData} == RESET_VAL)); // R6

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!armed)
    (!en) |=> $stable({rdPar, rdData})); // R8

  AST_NO_CHANGE_HOLDS: assert property (@(posedge clk) disable iff (!armed)
    (isNoChange && en && we && !srst) |=> $stable({rdPar, rdData})); // R5

  AST_WRITE_FIRST_SHOWS_NEW: assert property (@(posedge clk) disable iff (!armed)
    (isWriteFirst && en && we && !srst) |=> ({rdPar, rdData} == $past({wrPar, wrData}))); // R3

  AST_READ_BACK_LAST_WRITE: assert property (@(posedge clk) disable iff (!armedDeep)
    (en && !we && !srst && $past(en && we) && (addr == $past(addr)))
      |=> ({rdPar, rdData} == $past({wrPar, wrData}, 2))); // R2

endmodule

bind ram_sync_port ram_sync_port_chk #(
  .DATA_W    (DATA_W),
  .PAR_W     (PAR_W),
  .DEPTH     (DEPTH),
  .WRITE_MODE(WRITE_MODE),
  .RESET_VAL (RESET_VAL)
) u_chk (
  .clk   (clk),
  .en    (en),
  .we    (we),
  .srst  (srst),
  .addr  (addr),
  .wrData(wrData),
  .wrPar (wrPar),
  .rdData(rdData),
  .rdPar (rdPar)
);

// File: tb/ram_sync_port_bench.sv
module ram_sync_port_bench;
  import ram_port_pkg::*;

  localparam int DATA_W = 8;
  localparam int PAR_W  = 1;
  localparam int DEPTH  = 256;
  localparam int WORD_W = DATA_W + PAR_W;
  localparam logic [WORD_W-1:0] RV = 9'h12C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       en = 1'b0, we = 1'b0, srst = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrPar = 1'b0;
  logic [7:0] dData0, dData1, dData2;
  logic       dPar0, dPar1, dPar2;

  // Default policy (write-first, R9), read-first, no-change.
  ram_sync_port #(.RESET_VAL(RV)) u_ram_sync_port (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr),
    .wrData(wrData), .wrPar(wrPar), .rdData(dData0), .rdPar(dPar0));
  ram_sync_port #(.WRITE_MODE(WM_READ_FIRST), .RESET_VAL(RV)) u_ram_sync_port_rf (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr),
    .wrData(wrData), .wrPar(wrPar), .rdData(dData1), .rdPar(dPar1));
  ram_sync_port #(.WRITE_MODE(WM_NO_CHANGE), .RESET_VAL(RV)) u_ram_sync_port_nc (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr),
    .wrData(wrData), .wrPar(wrPar), .rdData(dData2), .rdPar(dPar2));

  typedef struct packed {
    logic [WORD_W-1:0] v0, v1, v2;
    logic              k0, k1, k2;
    logic [3:0]        c0, c1, c2;
  } expItem_t;

  expItem_t expQ[$];
  int testsRun = 0;
  int testsFailed = 0;

  // Reference model
  logic [WORD_W-1:0] refMem [DEPTH];
  bit                refValid [DEPTH];
  logic [WORD_W-1:0] refOut [3];
  bit                refKnown [3];
  logic [3:0]        refTag [3];

  function automatic string tagName(input logic [3:0] c);
    case (c)
      4'd1: return "R1/R2/R10 read";
      4'd3: return "R3/R9 write-first";
      4'd4: return "R4 read-first";
      4'd5: return "R5 no-change";
      4'd6: return "R6 set/reset";
      4'd7: return "R7 set/reset with write";
      4'd8: return "R8 disabled";
      default: return "R1";
    endcase
  endfunction

  task automatic drive(input logic iEn, input logic iWe, input logic iSrst,
                       input logic [7:0] iAddr, input logic [7:0] iData, input logic iPar);
    expItem_t it;
    logic [WORD_W-1:0] wWord;
    @(negedge clk);
    en = iEn; we = iWe; srst = iSrst; addr = iAddr; wrData = iData; wrPar = iPar;
    wWord = {iPar, iData};
    for (int m = 0; m < 3; m++) begin
      if (!iEn) begin
        refTag[m] = 4'd8;
      end else if (iSrst) begin
        refOut[m] = RV; refKnown[m] = 1'b1;
        refTag[m] = iWe ? 4'd7 : 4'd6;
      end else if (!iWe) begin
        refOut[m] = refMem[iAddr]; refKnown[m] = refValid[iAddr];
        refTag[m] = 4'd1;
      end else if (m == 0) begin
        refOut[m] = wWord; refKnown[m] = 1'b1; refTag[m] = 4'd3;
      end else if (m == 1) begin
        refOut[m] = refMem[iAddr]; refKnown[m] = refValid[iAddr]; refTag[m] = 4'd4;
      end else begin
        refTag[m] = 4'd5;
      end
    end
    if (iEn && iWe) begin
      refMem[iAddr] = wWord;
      refValid[iAddr] = 1'b1;
    end
    it.v0 = refOut[0]; it.v1 = refOut[1]; it.v2 = refOut[2];
    it.k0 = refKnown[0]; it.k1 = refKnown[1]; it.k2 = refKnown[2];
    it.c0 = refTag[0]; it.c1 = refTag[1]; it.c2 = refTag[2];
    expQ.push_back(it);
  endtask

  task automatic compareOne(input int dut, input logic [WORD_W-1:0] got,
                            input logic [WORD_W-1:0] exp, input logic known,
                            input logic [3:0] tag);
    if (known) begin
      testsRun++;
      if (got !== exp) begin
        testsFailed++;
        $display("FAIL %s dut=%0d got=%h exp=%h", tagName(tag), dut, got, exp);
      end
    end
  endtask

  // Monitor: outputs settle after the edge, sampled 1 ns later.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        compareOne(0, {dPar0, dData0}, it.v0, it.k0, it.c0);
        compareOne(1, {dPar1, dData1}, it.v1, it.k1, it.c1);
        compareOne(2, {dPar2, dData2}, it.v2, it.k2, it.c2);
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    #1500000;
    if (!finished) begin
      testsFailed++;
      $display("FAIL R1 watchdog got=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] rng;
    for (int i = 0; i < DEPTH; i++) refValid[i] = 1'b0;
    for (int m = 0; m < 3; m++) begin refKnown[m] = 1'b0; refOut[m] = '0; end

    drive(1, 0, 1, 8'd0, 8'h00, 0);      // R6 reset state
    drive(1, 1, 0, 8'd5, 8'h3C, 1);      // R3 R4 R5 with unknown old data
    drive(1, 1, 0, 8'd0, 8'hFF, 0);
    drive(1, 1, 0, 8'd255, 8'h81, 1);
    drive(1, 0, 0, 8'd5, 8'h00, 0);      // R1 R10
    drive(1, 0, 0, 8'd0, 8'h00, 0);
    drive(1, 0, 0, 8'd255, 8'h00, 0);
    drive(1, 1, 0, 8'd5, 8'hA5, 0);      // collision: RF shows 13C
    drive(1, 0, 0, 8'd5, 8'h00, 0);      // R2 readback
    drive(0, 1, 0, 8'd5, 8'h00, 1);      // R8 no write
    drive(1, 0, 0, 8'd5, 8'h00, 0);      // still A5
    drive(0, 0, 1, 8'd0, 8'h00, 0);      // R8 srst ignored
    drive(1, 0, 1, 8'd0, 8'h00, 0);      // R6
    drive(1, 0, 0, 8'd0, 8'h00, 0);      // array unchanged: FF
    drive(1, 1, 1, 8'd7, 8'h77, 1);      // R7
    drive(1, 0, 0, 8'd7, 8'h00, 0);      // R7 write landed
    drive(1, 1, 0, 8'd7, 8'h01, 0);      // collisions with known old data
    drive(1, 1, 0, 8'd7, 8'hFE, 1);

    rng = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      a = {4'd0, rng[3:0]};
      drive(rng[7:5] != 3'd0, rng[8], rng[13:9] == 5'd0, a, rng[23:16], rng[24]);
    end

    drive(1, 0, 0, 8'd0, 8'h00, 0);
    @(negedge clk); en = 0; we = 0; srst = 0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule